// File: doc/BRIEF.md
# Delayed-Read Expansion ROM Controller

This block answers 32-bit host reads that land in an expansion ROM address window. It does not stall the host while the slow, byte-wide ROM is read. The first read to a dword gets a retry. The block then records that dword's offset in its single pending slot and fetches the four bytes one at a time from a ROM read engine. When the host repeats the same read after the fetch has finished, the block returns the assembled dword and the slot becomes empty again.

There is only one slot. While a fetch is running, every read in the window is retried. Once a dword is ready, a read to any other offset in the window throws that dword away and starts a fetch for the new offset. The pending offset is kept in the ROM address register, which is also visible at a port. A status flag shows whether a fetch is in progress. Reads outside the window, or made while the window is disabled, get no response at all.

Top module: `xrom_dread_ctrl`

## Requirements
- R1: A read is a window hit only when `win_en_i` is 1 and bits [31:16] of `req_addr_i` equal bits [31:16] of `win_base_i`. A read that is not a hit produces no `rsp_valid_o` pulse and changes neither `busy_o` nor `rom_addr_reg_o`.
- R2: Every hit gives exactly one response: `rsp_valid_o` is high for the single cycle after the clock edge that sampled `req_i`. When the slot is empty, a hit is answered with a retry (`rsp_retry_o`=1), and `rom_addr_reg_o` takes `{req_addr_i[15:2], 2'b00}`.
- R3: `busy_o` goes to 1 at the edge that accepts a new fetch. It returns to 0 at the edge where the fourth byte is acknowledged.
- R4: While busy, the block asks for bytes 0 to 3 in order, at ROM addresses `rom_addr_reg_o`+0 to +3. Each request (`rom_rd_o` with `rom_addr_o`) is held until `rom_ack_i` arrives. The byte is taken from `rom_data_i` in the cycle of the acknowledge.
- R5: The byte fetched from offset +i is placed in bits [8i+7:8i] of the returned dword (little-endian).
- R6: When the fetch has finished, a hit whose address matches the pending dword (`req_addr_i[15:2]`) is answered with `rsp_retry_o`=0 and the assembled dword on `rsp_data_o`. This completes the transaction and empties the slot, so the next read of that address is retried again.
- R7: A hit that arrives while a fetch is in progress is retried, whether it is to the same offset or a different one. It leaves `rom_addr_reg_o` unchanged.
- R8: When the fetch has finished, a hit to a different dword offset is retried. The fetched data is discarded, `rom_addr_reg_o` takes the new offset, and a new fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| win_en_i | input | 1 | Window decode enable |
| win_base_i | input | 32 | Window base address; only bits [31:16] are compared |
| req_i | input | 1 | One-cycle host read attempt |
| req_addr_i | input | 32 | Host read byte address |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a hit |
| rsp_retry_o | output | 1 | The response is a retry |
| rsp_data_o | output | 32 | Completed dword; zero unless completing |
| busy_o | output | 1 | ROM fetch in progress |
| rom_addr_reg_o | output | 16 | ROM address register holding the pending dword address |
| rom_rd_o | output | 1 | Byte read request to the ROM engine |
| rom_addr_o | output | 16 | ROM byte address of the request |
| rom_ack_i | input | 1 | ROM engine acknowledge; data valid this cycle |
| rom_data_i | input | 8 | Byte returned by the ROM engine |

## Verification
The assertions check on every cycle the rules that hold at any moment:
- responses appear only after a request;
- the busy flag rises only after a request;
- ROM requests occur only while busy, keep a stable address until acknowledged, and always point inside the pending dword;
- the pending register does not move during a fetch;
- a completion never follows a busy cycle.

Only the bench scenarios can show:
- the order of the four byte addresses;
- the little-endian placement of the bytes;
- discarding a ready dword in favour of a new offset;
- the retry that follows a completed transaction;
- that reads outside the window, or made while it is disabled, leave everything untouched.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int unsigned DW_BYTES = 4;
  localparam int unsigned BIDX_W   = $clog2(DW_BYTES);
  localparam int unsigned DWORD_W  = 8 * DW_BYTES;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_FETCH = 2'd1,
    SLOT_READY = 2'd2
  } slot_state_e;
endpackage

// File: rtl/xrom_win_decode.sv
module xrom_win_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_AW = 16,
  localparam int unsigned DW_AW = WIN_AW - xrom_pkg::BIDX_W
) (
  input  logic              win_en_i,
  input  logic [ADDR_W-1:0] win_base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [DW_AW-1:0]  dw_off_o
);
  logic unused_base_lo;
  logic unused_addr_lo;

  // Window is naturally aligned: compare only the bits above the window size.
  assign hit_o    = win_en_i && (addr_i[ADDR_W-1:WIN_AW] == win_base_i[ADDR_W-1:WIN_AW]);
  assign dw_off_o = addr_i[WIN_AW-1:xrom_pkg::BIDX_W];

  assign unused_base_lo = ^win_base_i[WIN_AW-1:0];
  assign unused_addr_lo = ^addr_i[xrom_pkg::BIDX_W-1:0];
endmodule

// File: rtl/xrom_byte_fetch.sv
module xrom_byte_fetch #(
  parameter int unsigned WIN_AW = 16,
  localparam int unsigned DW_AW = WIN_AW - xrom_pkg::BIDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         active_i,
  input  logic [DW_AW-1:0]             pend_i,
  input  logic                         rom_ack_i,
  input  logic [7:0]                   rom_data_i,
  output logic                         rom_rd_o,
  output logic [WIN_AW-1:0]            rom_addr_o,
  output logic                         done_o,
  output logic [xrom_pkg::DWORD_W-1:0] dword_o
);
  import xrom_pkg::*;

  logic [BIDX_W-1:0] idx_q, idx_d;
  logic              take;

  assign take       = active_i && rom_ack_i;
  assign rom_rd_o   = active_i;
  assign rom_addr_o = {pend_i, idx_q};
  assign done_o     = take && (idx_q == BIDX_W'(DW_BYTES - 1));

  always_comb begin
    idx_d = idx_q;
    if (start_i)   idx_d = '0;
    else if (take) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // One byte lane register per dword byte, written little-endian.
  for (genvar g = 0; g < DW_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_we;
    assign lane_we = take && (idx_q == BIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_we) lane_q <= rom_data_i;
    end
    assign dword_o[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/xrom_slot_ctrl.sv
module xrom_slot_ctrl #(
  parameter int unsigned WIN_AW = 16,
  localparam int unsigned DW_AW = WIN_AW - xrom_pkg::BIDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hit_i,
  input  logic [DW_AW-1:0]             dw_off_i,
  input  logic                         fetch_done_i,
  input  logic [xrom_pkg::DWORD_W-1:0] dword_i,
  output logic                         start_o,
  output logic                         active_o,
  output logic [DW_AW-1:0]             pend_o,
  output logic                         rsp_valid_o,
  output logic                         rsp_retry_o,
  output logic [xrom_pkg::DWORD_W-1:0] rsp_data_o
);
  import xrom_pkg::*;

  slot_state_e        state_q, state_d;
  logic [DW_AW-1:0]   pend_q;
  logic               load_pend;
  logic               complete;
  logic               same_off;
  logic               rsp_valid_q, rsp_retry_q;
  logic [DWORD_W-1:0] rsp_data_q, rsp_data_d;

  assign same_off = (pend_q == dw_off_i);

  always_comb begin
    state_d   = state_q;
    load_pend = 1'b0;
    complete  = 1'b0;
    unique case (state_q)
      SLOT_EMPTY: if (hit_i) begin
        load_pend = 1'b1;
        state_d   = SLOT_FETCH;
      end
      SLOT_FETCH: if (fetch_done_i) state_d = SLOT_READY;
      SLOT_READY: if (hit_i) begin
        if (same_off) begin
          complete = 1'b1;
          state_d  = SLOT_EMPTY;
        end else begin
          load_pend = 1'b1;
          state_d   = SLOT_FETCH;
        end
      end
      default: state_d = SLOT_EMPTY;
    endcase
  end

  assign rsp_data_d = complete ? dword_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SLOT_EMPTY;
      rsp_valid_q <= 1'b0;
      rsp_retry_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= hit_i;
      rsp_retry_q <= hit_i && !complete;
      rsp_data_q  <= rsp_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= '0;
    else if (load_pend) pend_q <= dw_off_i;
  end

  assign start_o     = load_pend;
  assign active_o    = (state_q == SLOT_FETCH);
  assign pend_o      = pend_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_retry_o = rsp_retry_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/xrom_dread_ctrl.sv
module xrom_dread_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_AW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         win_en_i,
  input  logic [ADDR_W-1:0]            win_base_i,
  input  logic                         req_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  output logic                         rsp_valid_o,
  output logic                         rsp_retry_o,
  output logic [xrom_pkg::DWORD_W-1:0] rsp_data_o,
  output logic                         busy_o,
  output logic [WIN_AW-1:0]            rom_addr_reg_o,
  output logic                         rom_rd_o,
  output logic [WIN_AW-1:0]            rom_addr_o,
  input  logic                         rom_ack_i,
  input  logic [7:0]                   rom_data_i
);
  import xrom_pkg::*;
  localparam int unsigned DW_AW = WIN_AW - BIDX_W;

  logic               rst_meta_q, rst_sync_n;
  logic               win_hit, hit;
  logic [DW_AW-1:0]   dw_off, pend;
  logic               start, active, fetch_done;
  logic [DWORD_W-1:0] dword;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  xrom_win_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_dec (
    .win_en_i   (win_en_i),
    .win_base_i (win_base_i),
    .addr_i     (req_addr_i),
    .hit_o      (win_hit),
    .dw_off_o   (dw_off)
  );

  assign hit = req_i && win_hit;

  xrom_slot_ctrl #(.WIN_AW(WIN_AW)) u_slot (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .hit_i        (hit),
    .dw_off_i     (dw_off),
    .fetch_done_i (fetch_done),
    .dword_i      (dword),
    .start_o      (start),
    .active_o     (active),
    .pend_o       (pend),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_retry_o  (rsp_retry_o),
    .rsp_data_o   (rsp_data_o)
  );

  xrom_byte_fetch #(.WIN_AW(WIN_AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start),
    .active_i   (active),
    .pend_i     (pend),
    .rom_ack_i  (rom_ack_i),
    .rom_data_i (rom_data_i),
    .rom_rd_o   (rom_rd_o),
    .rom_addr_o (rom_addr_o),
    .done_o     (fetch_done),
    .dword_o    (dword)
  );

  assign busy_o         = active;
  assign rom_addr_reg_o = {pend, BIDX_W'(0)};
endmodule

// File: rtl/xrom_dread_chk.sv
module xrom_dread_chk #(
  parameter int unsigned WIN_AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              rsp_valid_o,
  input logic              rsp_retry_o,
  input logic              busy_o,
  input logic              rom_rd_o,
  input logic              rom_ack_i,
  input logic [WIN_AW-1:0] rom_addr_o,
  input logic [WIN_AW-1:0] rom_addr_reg_o
);
  // R2
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_i));

  // R3
  busy_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i));

  // R4
  rd_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_o |-> busy_o);

  // R4
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd_o && !rom_ack_i) |=> $stable(rom_addr_o));

  // R4
  rd_in_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_o |-> (rom_addr_o[WIN_AW-1:2] == rom_addr_reg_o[WIN_AW-1:2]));

  // R7
  pend_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o) |-> $stable(rom_addr_reg_o));

  // R6
  complete_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_retry_o) |-> !$past(busy_o));
endmodule

bind xrom_dread_ctrl xrom_dread_chk #(.WIN_AW(WIN_AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .req_i          (req_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_retry_o    (rsp_retry_o),
  .busy_o         (busy_o),
  .rom_rd_o       (rom_rd_o),
  .rom_ack_i      (rom_ack_i),
  .rom_addr_o     (rom_addr_o),
  .rom_addr_reg_o (rom_addr_reg_o)
);

// File: tb/xrom_dread_ctrl_tb.sv
module xrom_dread_ctrl_tb_top;
  localparam logic [31:0] BASE = 32'h000C_0000;
  localparam logic [31:0] ADR_A = BASE + 32'h0124;
  localparam logic [31:0] ADR_B = BASE + 32'h3F08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_en_i = 1'b1;
  logic [31:0] win_base_i = BASE;
  logic        req_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        rsp_valid_o, rsp_retry_o, busy_o, rom_rd_o;
  logic [31:0] rsp_data_o;
  logic [15:0] rom_addr_reg_o, rom_addr_o;
  logic        rom_ack_i = 1'b0;
  logic [7:0]  rom_data_i = '0;

  int checks = 0;
  int errors = 0;
  int lat = 2;
  int wcnt = 0;
  int nlog = 0;
  logic [15:0] alog [16];

  always #5 clk = ~clk;

  xrom_dread_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .win_en_i(win_en_i), .win_base_i(win_base_i),
    .req_i(req_i), .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o),
    .rsp_retry_o(rsp_retry_o), .rsp_data_o(rsp_data_o), .busy_o(busy_o),
    .rom_addr_reg_o(rom_addr_reg_o), .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o),
    .rom_ack_i(rom_ack_i), .rom_data_i(rom_data_i)
  );

  function automatic logic [7:0] rom_byte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] exp_dword(logic [31:0] addr);
    logic [15:0] b = {addr[15:2], 2'b00};
    return {rom_byte(b + 16'd3), rom_byte(b + 16'd2), rom_byte(b + 16'd1), rom_byte(b)};
  endfunction

  // ROM engine model: acknowledges each request after lat waiting cycles.
  always @(negedge clk) begin
    if (rom_ack_i) begin
      rom_ack_i = 1'b0;
      wcnt = 0;
    end else if (rom_rd_o) begin
      if (wcnt >= lat) begin
        rom_ack_i  = 1'b1;
        rom_data_i = rom_byte(rom_addr_o);
        if (nlog < 16) alog[nlog] = rom_addr_o;
        nlog++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one read attempt; returns the response seen the following cycle.
  task automatic host_read(input logic [31:0] a, output logic v, output logic r, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1;
    req_addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
    v = rsp_valid_o;
    r = rsp_retry_o;
    d = rsp_data_o;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy_o, "R3 reset busy", 32'(busy_o), 0);
    chk(!rsp_valid_o, "R2 reset rsp", 32'(rsp_valid_o), 0);
    chk(!rom_rd_o, "R4 reset rd", 32'(rom_rd_o), 0);
    chk(rom_addr_reg_o == 16'h0, "R2 reset reg", 32'(rom_addr_reg_o), 0);
  endtask

  task automatic t_outside();
    logic v, r; logic [31:0] d;
    host_read(32'h000D_0124, v, r, d);
    chk(!v, "R1 outside no rsp", 32'(v), 0);
    chk(!busy_o, "R1 outside busy", 32'(busy_o), 0);
    win_en_i = 1'b0;
    host_read(ADR_A, v, r, d);
    win_en_i = 1'b1;
    chk(!v, "R1 disabled no rsp", 32'(v), 0);
    chk(rom_addr_reg_o == 16'h0, "R1 reg untouched", 32'(rom_addr_reg_o), 0);
  endtask

  task automatic t_first_and_during();
    logic v, r; logic [31:0] d;
    nlog = 0;
    host_read(ADR_A + 32'd2, v, r, d);
    chk(v && r, "R2 first hit retry", {30'd0, v, r}, 32'h3);
    chk(rom_addr_reg_o == 16'h0124, "R2 reg capture", 32'(rom_addr_reg_o), 32'h0124);
    chk(busy_o, "R3 busy set", 32'(busy_o), 1);
    host_read(ADR_A, v, r, d);
    chk(v && r, "R7 same during fetch retry", {30'd0, v, r}, 32'h3);
    host_read(ADR_B, v, r, d);
    chk(v && r, "R7 other during fetch retry", {30'd0, v, r}, 32'h3);
    chk(rom_addr_reg_o == 16'h0124, "R7 reg kept", 32'(rom_addr_reg_o), 32'h0124);
    wait_idle();
    chk(!busy_o, "R3 busy clear", 32'(busy_o), 0);
    chk(nlog == 4, "R4 byte count", 32'(nlog), 4);
    for (int i = 0; i < 4; i++)
      chk(alog[i] == 16'h0124 + 16'(i), "R4 byte order", 32'(alog[i]), 32'h0124 + 32'(i));
  endtask

  task automatic t_complete();
    logic v, r; logic [31:0] d;
    host_read(ADR_A, v, r, d);
    chk(v && !r, "R6 complete", {30'd0, v, r}, 32'h2);
    chk(d == exp_dword(ADR_A), "R5 little-endian data", d, exp_dword(ADR_A));
    host_read(ADR_A, v, r, d);
    chk(v && r, "R6 slot emptied, retry", {30'd0, v, r}, 32'h3);
    chk(busy_o, "R6 refetch busy", 32'(busy_o), 1);
    wait_idle();
  endtask

  task automatic t_discard();
    logic v, r; logic [31:0] d;
    lat = 0;
    nlog = 0;
    host_read(ADR_B, v, r, d);
    chk(v && r, "R8 other offset retry", {30'd0, v, r}, 32'h3);
    chk(rom_addr_reg_o == 16'h3F08, "R8 reg new", 32'(rom_addr_reg_o), 32'h3F08);
    chk(busy_o, "R8 new fetch busy", 32'(busy_o), 1);
    wait_idle();
    chk(nlog == 4 && alog[0] == 16'h3F08 && alog[3] == 16'h3F0B, "R8 new addresses",
        32'(alog[3]), 32'h3F0B);
    host_read(ADR_B + 32'd1, v, r, d);
    chk(v && !r && d == exp_dword(ADR_B), "R8 new data R5", d, exp_dword(ADR_B));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_outside();
    t_first_and_during();
    t_complete();
    t_discard();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule